// File: doc/BRIEF.md
# Factory Bad-Block Map Builder

This block walks every erase block of a NAND array once after reset and records in a bitmap which blocks were marked unusable at the factory. For each block it asks an external NAND sequencer to read one byte. That byte is the marker in the spare area of the block's first page, reached through the spare-area pointer command with an offset of five. The block then classifies the returned byte and writes one bit for that block into the bitmap.

When the pass is over, other logic queries the bitmap through a registered lookup port. A running total of bad blocks is output. A fault flag rises when that total goes over the number of bad blocks the device is allowed to have. A start pulse given after a pass has finished clears the map and runs the whole pass again.

Top module: `bbt_builder`

## Requirements
- R1: While reset is held and immediately after it is released, `busy` is 1, `done` is 0, `bad_count` is 0, and the block presents a request for row 0.
- R2: Every request carries command byte 50h and column 5, the sixth spare byte of the page. Its row is the first page of the block, so the low log2(PAGES_PER_BLOCK) row bits are 0.
- R3: Blocks are requested in ascending order 0 to NUM_BLOCKS-1, one request per block, at row = block × PAGES_PER_BLOCK.
- R4: `req_valid` and `req_row` hold steady until `req_ack` is seen high on a rising edge. In the cycle after that edge, `req_valid` is 0 until the response has been taken.
- R5: A block is bad when its marker byte has two or more 0 bits. For example, 00h, FCh, BDh and 7Eh are bad, while FFh, FEh, 7Fh and EFh are good.
- R6: `bad_count` rises by one on the edge where a response with a bad marker is taken. Otherwise it does not change.
- R7: After the response for the last block has been taken, `done` is 1, `busy` is 0 and no further request is issued. `done` and `busy` are never equal.
- R8: `lookup_bad` shows the map bit for `lookup_blk` one clock after `lookup_blk` is sampled, where 1 means bad.
- R9: `dev_fault` is 1 exactly when `bad_count` exceeds MAX_BAD (default 70). A count of 70 is not a fault and a count of 71 is.
- R10: A `start` pulse while `done` is 1 clears the map and the count, then rescans from block 0. A `start` pulse while `busy` is 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Re-run pulse, honoured only when done |
| req_valid | output | 1 | Read request pending |
| req_ack | input | 1 | Sequencer accepted the request |
| req_cmd | output | 8 | Pointer command byte (50h) |
| req_row | output | ROW_W (17) | Page row address |
| req_col | output | COL_W (8) | Column offset inside the spare area |
| rsp_valid | input | 1 | Marker byte is valid |
| rsp_byte | input | 8 | Marker byte read back |
| lookup_blk | input | BLK_W (12) | Block to query |
| lookup_bad | output | 1 | Registered map bit for the queried block |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan finished |
| bad_count | output | CNT_W (13) | Bad blocks found so far |
| dev_fault | output | 1 | Bad-block total above the limit |

## Verification
The bench feeds markers with exactly one zero bit (FEh, 7Fh, EFh) next to markers with exactly two zero bits (FCh, BDh, 7Eh). A design that treated any value other than FFh as bad would overcount, and one that needed more zeros would undercount. The first pass produces exactly 70 bad blocks and the second produces 71, so an off-by-one in the fault threshold shows up on one side or the other. Acknowledge and response latencies vary from block to block, which exposes a design that advances before the handshake or drops the request early. The bench also pulses start in the middle of a scan and reads a block that was bad in the previous pass before that block has been rescanned, which catches a restart that should have been ignored and a map that was never cleared.

// File: rtl/bbt_pkg.sv
package bbt_pkg;
    typedef enum logic [1:0] {
        ST_ISSUE = 2'd0,
        ST_WAIT  = 2'd1,
        ST_DONE  = 2'd2
    } scan_st_e;

    localparam logic [7:0] CMD_SPARE_PTR = 8'h50;
endpackage

// File: rtl/bbt_marker_eval.sv
module bbt_marker_eval #(
    parameter int BYTE_W    = 8,
    parameter int MIN_ZEROS = 2
) (
    input  logic [BYTE_W-1:0] marker_i,
    output logic              is_bad_o
);
    localparam int ZW = $clog2(BYTE_W + 1);

    logic [ZW-1:0] zeros;

    always_comb begin
        zeros = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            zeros = zeros + ZW'(~marker_i[i]);
        end
    end

    assign is_bad_o = (zeros >= ZW'(MIN_ZEROS));
endmodule

// File: rtl/bbt_bitmap.sv
module bbt_bitmap #(
    parameter int DEPTH = 4096,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic          wr_bit_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic          rd_bit_o
);
    logic [DEPTH-1:0] bits_d, bits_q;
    logic             rd_d, rd_q;

    always_comb begin
        bits_d = bits_q;
        if (clr_i) begin
            bits_d = '0;
        end
        if (wr_en_i) begin
            bits_d[wr_addr_i] = wr_bit_i;
        end
        rd_d = bits_q[rd_addr_i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
            rd_q   <= 1'b0;
        end else begin
            bits_q <= bits_d;
            rd_q   <= rd_d;
        end
    end

    assign rd_bit_o = rd_q;
endmodule

// File: rtl/bbt_scan_ctrl.sv
module bbt_scan_ctrl
    import bbt_pkg::*;
#(
    parameter int NUM_BLOCKS = 4096,
    localparam int BLK_W     = $clog2(NUM_BLOCKS),
    localparam int CNT_W     = $clog2(NUM_BLOCKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             req_ack_i,
    input  logic             rsp_valid_i,
    input  logic             is_bad_i,
    output logic             req_valid_o,
    output logic [BLK_W-1:0] blk_o,
    output logic             clr_o,
    output logic             wr_en_o,
    output logic             busy_o,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);

    typedef struct packed {
        scan_st_e         st;
        logic [BLK_W-1:0] blk;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    ctrl_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        clr_o   = 1'b0;
        wr_en_o = 1'b0;
        case (r_q.st)
            ST_ISSUE: begin
                if (req_ack_i) begin
                    r_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (rsp_valid_i) begin
                    wr_en_o = 1'b1;
                    if (is_bad_i) begin
                        r_d.cnt = r_q.cnt + CNT_W'(1);
                    end
                    if (r_q.blk == LAST_BLK) begin
                        r_d.st = ST_DONE;
                    end else begin
                        r_d.blk = r_q.blk + BLK_W'(1);
                        r_d.st  = ST_ISSUE;
                    end
                end
            end
            ST_DONE: begin
                if (start_i) begin
                    clr_o   = 1'b1;
                    r_d.blk = '0;
                    r_d.cnt = '0;
                    r_d.st  = ST_ISSUE;
                end
            end
            default: r_d.st = ST_DONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st  <= ST_ISSUE;
            r_q.blk <= '0;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_valid_o = (r_q.st == ST_ISSUE);
    assign busy_o      = (r_q.st != ST_DONE);
    assign blk_o       = r_q.blk;
    assign count_o     = r_q.cnt;
endmodule

// File: rtl/bbt_builder.sv
module bbt_builder
    import bbt_pkg::*;
#(
    parameter int NUM_BLOCKS      = 4096,
    parameter int PAGES_PER_BLOCK = 32,
    parameter int SPARE_OFFSET    = 5,
    parameter int MAX_BAD         = 70,
    parameter int MIN_ZEROS       = 2,
    parameter int COL_W           = 8,
    localparam int BLK_W          = $clog2(NUM_BLOCKS),
    localparam int PG_W           = $clog2(PAGES_PER_BLOCK),
    localparam int ROW_W          = BLK_W + PG_W,
    localparam int CNT_W          = $clog2(NUM_BLOCKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             req_valid,
    input  logic             req_ack,
    output logic [7:0]       req_cmd,
    output logic [ROW_W-1:0] req_row,
    output logic [COL_W-1:0] req_col,
    input  logic             rsp_valid,
    input  logic [7:0]       rsp_byte,
    input  logic [BLK_W-1:0] lookup_blk,
    output logic             lookup_bad,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] bad_count,
    output logic             dev_fault
);
    logic             is_bad;
    logic             clr;
    logic             wr_en;
    logic [BLK_W-1:0] blk;

    bbt_marker_eval #(
        .BYTE_W   (8),
        .MIN_ZEROS(MIN_ZEROS)
    ) u_eval (
        .marker_i(rsp_byte),
        .is_bad_o(is_bad)
    );

    bbt_scan_ctrl #(
        .NUM_BLOCKS(NUM_BLOCKS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .req_ack_i  (req_ack),
        .rsp_valid_i(rsp_valid),
        .is_bad_i   (is_bad),
        .req_valid_o(req_valid),
        .blk_o      (blk),
        .clr_o      (clr),
        .wr_en_o    (wr_en),
        .busy_o     (busy),
        .count_o    (bad_count)
    );

    bbt_bitmap #(
        .DEPTH(NUM_BLOCKS)
    ) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr),
        .wr_en_i  (wr_en),
        .wr_addr_i(blk),
        .wr_bit_i (is_bad),
        .rd_addr_i(lookup_blk),
        .rd_bit_o (lookup_bad)
    );

    // first page of the block: block index in the upper row bits
    assign req_row   = {blk, {PG_W{1'b0}}};
    assign req_cmd   = CMD_SPARE_PTR;
    assign req_col   = COL_W'(SPARE_OFFSET);
    assign done      = !busy;
    assign dev_fault = (bad_count > CNT_W'(MAX_BAD));
endmodule

// File: rtl/bbt_builder_chk.sv
module bbt_builder_chk #(
    parameter int ROW_W        = 17,
    parameter int COL_W        = 8,
    parameter int CNT_W        = 13,
    parameter int PG_W         = 5,
    parameter int SPARE_OFFSET = 5,
    parameter int MAX_BAD      = 70
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             req_valid,
    input logic             req_ack,
    input logic [7:0]       req_cmd,
    input logic [ROW_W-1:0] req_row,
    input logic [COL_W-1:0] req_col,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] bad_count,
    input logic             dev_fault
);
    assert_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_cmd == 8'h50 && req_col == COL_W'(SPARE_OFFSET)
                       && req_row[PG_W-1:0] == '0));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ack) |=> (req_valid && $stable(req_row)));

    assert_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ack) |=> !req_valid);

    assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (bad_count == $past(bad_count)
                  || bad_count == $past(bad_count) + CNT_W'(1)));

    assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy != done);

    assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_valid);

    assert_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_fault) |-> (bad_count == CNT_W'(MAX_BAD + 1)));

    assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(bad_count)));
endmodule

bind bbt_builder bbt_builder_chk #(
    .ROW_W       (ROW_W),
    .COL_W       (COL_W),
    .CNT_W       (CNT_W),
    .PG_W        (PG_W),
    .SPARE_OFFSET(SPARE_OFFSET),
    .MAX_BAD     (MAX_BAD)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .req_valid(req_valid),
    .req_ack  (req_ack),
    .req_cmd  (req_cmd),
    .req_row  (req_row),
    .req_col  (req_col),
    .busy     (busy),
    .done     (done),
    .bad_count(bad_count),
    .dev_fault(dev_fault)
);

// File: tb/sim_bbt_builder.sv
module sim_bbt_builder;
    localparam int NB    = 4096;
    localparam int PG    = 32;
    localparam int ROW_W = 17;
    localparam int BLK_W = 12;
    localparam int CNT_W = 13;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             req_ack = 1'b0;
    logic             rsp_valid = 1'b0;
    logic [7:0]       rsp_byte = 8'h00;
    logic [BLK_W-1:0] lookup_blk = '0;
    logic             req_valid;
    logic [7:0]       req_cmd;
    logic [ROW_W-1:0] req_row;
    logic [7:0]       req_col;
    logic             lookup_bad;
    logic             busy;
    logic             done;
    logic [CNT_W-1:0] bad_count;
    logic             dev_fault;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int exp_count = 0;
    bit exp_table [NB];

    bbt_builder u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .req_valid(req_valid), .req_ack(req_ack), .req_cmd(req_cmd),
        .req_row(req_row), .req_col(req_col),
        .rsp_valid(rsp_valid), .rsp_byte(rsp_byte),
        .lookup_blk(lookup_blk), .lookup_bad(lookup_bad),
        .busy(busy), .done(done), .bad_count(bad_count), .dev_fault(dev_fault)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int zeros(input logic [7:0] v);
        int z = 0;
        for (int i = 0; i < 8; i++) z += (v[i] == 1'b0) ? 1 : 0;
        return z;
    endfunction

    // Scan 1 yields 70 bad blocks, scan 2 adds block 2 for 71.
    function automatic logic [7:0] mark_of(input int b, input int scan);
        if (scan == 2 && b == 2) return 8'h7E;
        if (b == 3) return 8'hEF;
        if (b == 0 || b == 1 || b == 11 || b == 13 || b == 4094 || b == 4095) return 8'hBD;
        case (b % 128)
            7:       return 8'h00;
            50:      return 8'hFC;
            90:      return 8'hFE;
            100:     return 8'h7F;
            default: return 8'hFF;
        endcase
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // per-clock model comparison of flag relations
    always @(negedge clk) begin
        if (rst_n) begin
            chk(done != busy, "R7", done, !busy);
            chk(dev_fault == (int'(bad_count) > 70), "R9", dev_fault, int'(bad_count) > 70);
        end
    end

    task automatic run_scan(input int scan);
        for (int b = 0; b < NB; b++) begin
            if (scan == 2 && b == 2) begin
                lookup_blk = BLK_W'(4095);   // bad in scan 1, not yet rescanned
                @(negedge clk);
                chk(lookup_bad == 1'b0, "R10", lookup_bad, 0);
            end
            while (!req_valid) @(negedge clk);
            chk(req_row == ROW_W'(b * PG), "R3", req_row, b * PG);
            chk(req_cmd == 8'h50 && req_col == 8'd5, "R2", {req_cmd, req_col}, 16'h5005);
            for (int d = 0; d < (b * 7) % 3; d++) begin
                if (scan == 2 && b == 100) start = 1'b1;  // ignored while busy
                @(negedge clk);
                start = 1'b0;
                chk(req_valid == 1'b1 && req_row == ROW_W'(b * PG), "R4", req_row, b * PG);
            end
            req_ack = 1'b1;
            @(negedge clk);
            req_ack = 1'b0;
            chk(req_valid == 1'b0, "R4", req_valid, 0);
            for (int d = 0; d < b % 3; d++) @(negedge clk);
            rsp_byte  = mark_of(b, scan);
            rsp_valid = 1'b1;
            @(negedge clk);
            rsp_valid = 1'b0;
            exp_table[b] = (zeros(rsp_byte) >= 2);
            if (exp_table[b]) exp_count++;
            chk(int'(bad_count) == exp_count, "R6", bad_count, exp_count);
        end
        chk(done && !busy && !req_valid, "R7", {done, busy, req_valid}, 3'b100);
    endtask

    task automatic look(input int b, input string req);
        lookup_blk = BLK_W'(b);
        @(negedge clk);
        chk(lookup_bad == exp_table[b], req, lookup_bad, exp_table[b]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && bad_count == '0 && busy == 1'b1, "R1", {busy, done}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_valid == 1'b1 && req_row == '0, "R1", req_row, 0);

        run_scan(1);
        chk(int'(bad_count) == 70, "R9", bad_count, 70);
        chk(dev_fault == 1'b0, "R9", dev_fault, 0);
        look(0, "R8");
        look(4095, "R8");
        look(7, "R5");
        look(50, "R5");
        look(90, "R5");
        look(100, "R5");
        look(3, "R5");
        look(2, "R8");
        look(135, "R8");
        repeat (5) @(negedge clk);
        chk(done && !req_valid && int'(bad_count) == 70, "R7", bad_count, 70);

        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        exp_count = 0;
        chk(busy == 1'b1 && bad_count == '0, "R10", bad_count, 0);
        run_scan(2);
        chk(int'(bad_count) == 71, "R9", bad_count, 71);
        chk(dev_fault == 1'b1, "R9", dev_fault, 1);
        look(2, "R5");
        look(4095, "R10");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule